// File: doc/BRIEF.md
# Single-Wire LED Pulse Encoder

This block serialises color bytes onto one output wire using the clockless pulse-width code that addressable RGB and RGBW LED strings accept at 800 kbit/s. Every bit is a fixed-length period that begins with the line high. A short high time encodes a zero and a long high time encodes a one. All cycle counts come from the clock-frequency parameter `CLK_HZ`. The zero-bit high count is truncated toward zero. The one-bit high count and the period count are rounded to the nearest cycle. Elaboration stops with an error if the clock is too slow to keep the zero-bit high time at or under 550 ns, or to give it at least one cycle.

To send a frame, a one-cycle `start` pulse is given in idle. On that cycle the block captures the LED count and the per-LED byte mode: three bytes per LED, or four bytes per LED when `rgbw_mode` is set. Bytes are then pulled through a valid/ready handshake just in time, so consecutive bytes leave back to back. After the last byte, or as soon as a needed byte is missing, the line rests low for the latch interval. A one-cycle `done` then marks the point where the next frame may begin.

Top module: `nrz_led_encoder`

## Requirements
- R1: After reset and while idle, `data_out`, `in_ready` and `done` are all low.
- R2: Each bit lasts PERIOD cycles and starts high. The high time is ZERO cycles for a 0 bit and ONE cycles for a 1 bit, with ZERO = floor(350 ns), ONE = round(900 ns) and PERIOD = round(1250 ns) in clock cycles (43, 113 and 156 at 125 MHz).
- R3: Bits of a byte leave most significant first, and the first bit of the next byte follows the last bit of the previous byte with no idle cycle.
- R4: A frame carries `led_count`×3 bytes when `rgbw_mode`=0 and `led_count`×4 bytes when `rgbw_mode`=1, using the values sampled with `start`.
- R5: After the frame the line stays low for the latch interval: ceil(50 µs) cycles in 3-byte mode and ceil(80 µs) cycles in 4-byte mode (6250 and 10000 at 125 MHz). A frame with `led_count`=0 is a latch interval only.
- R6: `in_ready` is high only in the cycle after an accepted `start` of a non-empty frame, and in the last cycle of each byte that is not the final byte of the frame. It is never high while idle, even with `in_valid` high.
- R7: If `in_valid` is low when a byte is needed, the frame ends at that point and the latch interval begins.
- R8: `done` is high for exactly one cycle, the last cycle of the latch interval, and `start` is accepted from the following cycle.
- R9: `start`, `rgbw_mode` and `led_count` have no effect while a frame or its latch interval is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a frame when idle |
| rgbw_mode | input | 1 | 0: three bytes per LED, 1: four bytes per LED |
| led_count | input | COUNT_W | Number of LEDs in the frame |
| in_data | input | 8 | Color byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Encoder takes a byte this cycle if valid |
| data_out | output | 1 | Single-wire pulse-coded output |
| done | output | 1 | One-cycle pulse at the end of the latch interval |

## Verification
The line is compared on every clock against a reference waveform that is built from the byte list. Byte patterns mixing 0xA5, 0x00, 0xFF, 0x80, 0x01 and 0xC3 separate zero and one high times, expose a reversed bit order, and reveal any gap at byte boundaries. Frames in both byte modes, a zero-LED frame and an underrun frame that supplies two of six bytes distinguish the frame length, the two latch lengths and early termination. A `start` pulse with a changed mode and count in the middle of a frame, and `in_valid` held high while idle, show whether mid-frame commands or idle data leak through.

// File: rtl/nrz_pkg.sv
package nrz_pkg;

    localparam longint NS_BIT_ZERO   = 350;
    localparam longint NS_BIT_ONE    = 900;
    localparam longint NS_BIT_PERIOD = 1250;
    localparam longint NS_ZERO_LIMIT = 550;
    localparam longint US_GAP_RGB    = 50;
    localparam longint US_GAP_RGBW   = 80;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SEND,
        ST_LATCH
    } enc_state_t;

    typedef struct packed {
        logic active;
        logic last_cycle;
    } shaper_stat_t;

    // nanoseconds to cycles, truncated
    function automatic int ns_floor(longint hz, longint ns);
        return int'(((hz / 1000) * ns) / 1000000);
    endfunction

    // nanoseconds to cycles, rounded to nearest
    function automatic int ns_round(longint hz, longint ns);
        return int'(((hz / 1000) * ns + 500000) / 1000000);
    endfunction

    // microseconds to cycles, rounded up so the gap is never short
    function automatic int us_ceil(longint hz, longint us);
        return int'(((hz / 1000) * us * 1000 + 999999) / 1000000);
    endfunction

    function automatic bit zero_time_ok(longint hz);
        longint z;
        z = longint'(ns_floor(hz, NS_BIT_ZERO));
        return (z >= 1) && ((z * 1000000000) / hz <= NS_ZERO_LIMIT);
    endfunction

endpackage

// File: rtl/nrz_bit_shaper.sv
module nrz_bit_shaper
    import nrz_pkg::*;
#(
    parameter int CLK_HZ = 125000000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [7:0]   load_byte,
    output logic         line,
    output shaper_stat_t stat
);
    localparam int PERIOD = ns_round(CLK_HZ, NS_BIT_PERIOD);
    localparam int HI_ONE = ns_round(CLK_HZ, NS_BIT_ONE);
    localparam int HI_ZERO = ns_floor(CLK_HZ, NS_BIT_ZERO);
    localparam int TW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] PER_LAST = TW'(PERIOD - 1);
    localparam logic [TW-1:0] ONE_T = TW'(HI_ONE);
    localparam logic [TW-1:0] ZERO_T = TW'(HI_ZERO);

    logic [TW-1:0] phase;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          active;
    logic          at_period_end;

    assign at_period_end   = active && (phase == PER_LAST);
    assign stat.active     = active;
    assign stat.last_cycle = at_period_end && (bit_idx == 3'd7);
    assign line = active && (phase < (shreg[7] ? ONE_T : ZERO_T));

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else if (load) begin
            active  <= 1'b1;
            phase   <= '0;
            bit_idx <= '0;
            shreg   <= load_byte;
        end else if (active) begin
            if (at_period_end) begin
                phase <= '0;
                if (bit_idx == 3'd7) begin
                    active <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 3'd1;
                    shreg   <= {shreg[6:0], 1'b0};
                end
            end else begin
                phase <= phase + TW'(1);
            end
        end
    end

    // R2: a bit that is not the last of its byte is followed at once by a new period
    assert_bit_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (at_period_end && bit_idx != 3'd7 && !load) |=> (active && phase == '0 && line))
        else $error("bit period did not restart high");

    // R3: the next bit sent is the following lower bit of the byte
    assert_msb_order_R3: assert property (@(posedge clk) disable iff (rst)
        (at_period_end && bit_idx != 3'd7 && !load) |=> (shreg[7] == $past(shreg[6])))
        else $error("bit order broken");

endmodule

// File: rtl/nrz_latch_timer.sv
module nrz_latch_timer
    import nrz_pkg::*;
#(
    parameter int CLK_HZ = 125000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic wide_mode,
    output logic expired
);
    localparam int GAP3 = us_ceil(CLK_HZ, US_GAP_RGB);
    localparam int GAP4 = us_ceil(CLK_HZ, US_GAP_RGBW);
    localparam int GAP_MAX = (GAP4 > GAP3) ? GAP4 : GAP3;
    localparam int LW = $clog2(GAP_MAX + 1);
    localparam logic [LW-1:0] LAST3 = LW'(GAP3 - 1);
    localparam logic [LW-1:0] LAST4 = LW'(GAP4 - 1);

    logic [LW-1:0] cnt;
    logic [LW-1:0] last;

    assign last    = wide_mode ? LAST4 : LAST3;
    assign expired = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + LW'(1);
        end
    end

    // R5: the gap counter never runs past the interval of the captured mode
    assert_gap_bound_R5: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= (wide_mode ? LAST4 : LAST3)))
        else $error("latch counter overran");

endmodule

// File: rtl/nrz_led_encoder.sv
module nrz_led_encoder
    import nrz_pkg::*;
#(
    parameter int CLK_HZ  = 125000000,
    parameter int COUNT_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               rgbw_mode,
    input  logic [COUNT_W-1:0] led_count,
    input  logic [7:0]         in_data,
    input  logic               in_valid,
    output logic               in_ready,
    output logic               data_out,
    output logic               done
);
    localparam int BW = COUNT_W + 2;

    if (!zero_time_ok(CLK_HZ)) begin : g_clk_too_slow
        $error("CLK_HZ cannot meet the zero-bit high time limit");
    end

    enc_state_t    state;
    logic          mode_q;
    logic [BW-1:0] left_q;
    logic [BW-1:0] count_ext;
    logic [BW-1:0] frame_len;
    logic          take;
    logic          gap_over;
    shaper_stat_t  stat;

    assign count_ext = {2'b00, led_count};
    assign frame_len = rgbw_mode ? (count_ext << 2) : (count_ext + (count_ext << 1));

    assign in_ready = (state == ST_FETCH) ||
                      ((state == ST_SEND) && stat.last_cycle && (left_q != '0));
    assign take = in_ready && in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            mode_q <= 1'b0;
            left_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    mode_q <= rgbw_mode;
                    left_q <= frame_len;
                    state  <= (frame_len == '0) ? ST_LATCH : ST_FETCH;
                end
                ST_FETCH: if (in_valid) begin
                    left_q <= left_q - BW'(1);
                    state  <= ST_SEND;
                end else begin
                    state <= ST_LATCH;
                end
                ST_SEND: if (stat.last_cycle) begin
                    if (take) begin
                        left_q <= left_q - BW'(1);
                    end else begin
                        state <= ST_LATCH;
                    end
                end
                ST_LATCH: if (gap_over) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    nrz_bit_shaper #(.CLK_HZ(CLK_HZ)) u_shaper (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .load_byte (in_data),
        .line      (data_out),
        .stat      (stat)
    );

    nrz_latch_timer #(.CLK_HZ(CLK_HZ)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .run       (state == ST_LATCH),
        .wide_mode (mode_q),
        .expired   (gap_over)
    );

    assign done = gap_over;

    // R1: line rests low while idle
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!data_out && !in_ready))
        else $error("idle output not low");

    // R2: an accepted byte starts a bit with the line high
    assert_load_high_R2: assert property (@(posedge clk) disable iff (rst)
        take |=> data_out)
        else $error("bit did not start high");

    // R3: no gap between bytes while sending
    assert_no_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SEND) |-> stat.active)
        else $error("shaper idle during frame");

    // R5: latch interval is low
    assert_gap_low_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH) |-> !data_out)
        else $error("line high during latch");

    // R8: done is a single cycle and returns to idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && state == ST_IDLE))
        else $error("done not a single pulse");

endmodule

// File: tb/nrz_led_encoder_test.sv
module nrz_led_encoder_test;
    // 125 MHz: zero high 43, one high 113, period 156, gaps 6250 / 10000 cycles
    localparam int T_PER  = 156;
    localparam int T_ONE  = 113;
    localparam int T_ZERO = 43;
    localparam int G_RGB  = 6250;
    localparam int G_RGBW = 10000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rgbw_mode = 1'b0;
    logic [9:0] led_count = '0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       data_out;
    logic       done;

    always #4 clk = ~clk;

    nrz_led_encoder #(.CLK_HZ(125000000), .COUNT_W(10)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rgbw_mode (rgbw_mode),
        .led_count (led_count),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .data_out  (data_out),
        .done      (done)
    );

    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;
    logic [7:0] src[$];
    int    idx = 0;
    int    nsup = 0;
    bit    pending = 0;
    bit    q_line[$];
    bit    q_rdy[$];
    bit    q_done[$];
    string q_tag[$];
    string idle_tag = "R1";

    task automatic cmp(string tag, string name, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %b expected %b at %0t", tag, name, got, exp, $time);
        end
    endtask

    task automatic push(bit l, bit r, bit d, string t);
        q_line.push_back(l);
        q_rdy.push_back(r);
        q_done.push_back(d);
        q_tag.push_back(t);
    endtask

    // one negedge step: account handshake, compare, drive
    task automatic tick();
        bit el, er, ed;
        string tg;
        if (pending) idx++;
        if (q_line.size() > 0) begin
            el = q_line.pop_front();
            er = q_rdy.pop_front();
            ed = q_done.pop_front();
            tg = q_tag.pop_front();
        end else begin
            el = 0; er = 0; ed = 0; tg = idle_tag;
        end
        cmp(tg, "data_out", data_out, el);
        cmp(tg, "in_ready", in_ready, er);
        cmp(tg, "done", done, ed);
        in_valid = (idx < nsup);
        in_data  = in_valid ? src[idx] : 8'h00;
        pending  = in_valid && in_ready;
    endtask

    task automatic expect_frame(bit mode, int leds, string tb, string tl);
        int total, used, gap;
        total = leds * (mode ? 4 : 3);
        used  = (nsup < total) ? nsup : total;
        gap   = mode ? G_RGBW : G_RGB;
        if (total > 0) push(0, 1, 0, "R6");
        for (int b = 0; b < used; b++) begin
            for (int k = 0; k < 8; k++) begin
                for (int t = 0; t < T_PER; t++) begin
                    bit hi, rd;
                    hi = (t < (src[b][7-k] ? T_ONE : T_ZERO));
                    rd = (k == 7) && (t == T_PER - 1) && (b < total - 1);
                    push(hi, rd, 0, rd ? "R6" : tb);
                end
            end
        end
        for (int i = 0; i < gap; i++) begin
            push(0, 0, i == gap - 1, (i == gap - 1) ? "R8" : tl);
        end
    endtask

    task automatic run_frame(bit mode, int leds, int supply, string tb, string tl, int glitch_at);
        int k;
        nsup = supply;
        idx = 0;
        start = 1'b1;
        rgbw_mode = mode;
        led_count = 10'(leds);
        expect_frame(mode, leds, tb, tl);
        k = 0;
        while (q_line.size() > 0) begin
            @(negedge clk);
            tick();
            k++;
            if (k == glitch_at) begin
                start = 1'b1;
                rgbw_mode = !mode;
                led_count = 10'd5;
            end else begin
                start = 1'b0;
            end
        end
        repeat (3) begin
            @(negedge clk);
            tick();
            start = 1'b0;
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle_tag = "R1";
        repeat (4) begin
            @(negedge clk);
            tick();
        end
        // R6: valid data while idle is not taken
        idle_tag = "R6";
        src = {8'h11};
        nsup = 1;
        idx = 0;
        repeat (6) begin
            @(negedge clk);
            tick();
        end
        idle_tag = "R1";
        // R2: zero and one high times, 3-byte mode
        src = {8'hA5, 8'h00, 8'hFF};
        run_frame(1'b0, 1, 3, "R2", "R5", 0);
        // R3: bit order and back-to-back bytes, 4-byte mode gap
        src = {8'h80, 8'h01, 8'h7E, 8'hC3};
        run_frame(1'b1, 1, 4, "R3", "R5", 0);
        // R4 length of two LEDs; R9 mid-frame start with other mode ignored
        src = {8'h12, 8'h34, 8'h56, 8'h9A, 8'hBC, 8'hF0};
        run_frame(1'b0, 2, 6, "R4", "R9", 2000);
        // R7: underrun after two bytes
        src = {8'hFE, 8'h01};
        run_frame(1'b0, 2, 2, "R7", "R7", 0);
        // R5: empty frame is a latch interval only
        src = {};
        run_frame(1'b0, 0, 0, "R5", "R5", 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog cycles got 200000 expected fewer");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule